// File: doc/BRIEF.md
# Matching Pursuit Sparse Recovery Engine

The engine rebuilds a sparse coefficient vector from a short vector of compressed measurements by greedy matching pursuit. An M-row by N-column dictionary of 8-bit signed entries and an M-word measurement vector are written into on-chip registers while the engine is idle. A start pulse copies the measurements into a working residual. The engine then runs a fixed number of iterations. In each one it correlates the residual against every dictionary column, picks the column with the largest correlation magnitude, adds the scaled coefficient to that column's estimate and subtracts the scaled column from the residual.

The correlation search uses LANES multiply-accumulate lanes. Each lane owns one column of a group of LANES columns and steps through the M rows one per cycle. The groups are swept in turn, with one compare cycle after each group. Dictionary entries are taken as Q1.7 fractions with unit-norm columns, so the coefficient is the correlation shifted right by 7. Once the last iteration ends, a done pulse is issued and the N estimates are streamed out one per cycle. For more throughput, several independent engines can each take their own measurement block.

Top module: `mp_engine`

## Requirements
- R1: After reset, busy, done and coef_valid are low, the estimate and residual are zero, and the measurement write position is row 0.
- R2: A start pulse while idle raises busy in the next cycle. Busy stays high through the last streamed coefficient. A start pulse while busy has no effect on timing or results.
- R3: Every correlation is exact for any 8-bit signed entries, including the extreme case of all entries at -128. The accumulators are 16 + clog2(M) bits wide.
- R4: Each iteration chooses the column with the largest absolute correlation. When two columns have the same magnitude, the lower column index wins.
- R5: The step size is alpha = c >>> 7 (arithmetic shift, floor), where c is the chosen column's correlation. Alpha is added to that column's estimate only. All estimates start at zero for each block.
- R6: The residual starts as the measurement vector. Each iteration replaces every residual entry r[i] with r[i] - ((alpha * D[i][j]) >>> 7), saturated to the range -128..127.
- R7: Exactly ITERS (default 10) iterations run per block. Let the start edge be the clock edge that samples start. Done is high for one cycle, beginning ITERS*((N/LANES)*(M+1)+1) edges after the start edge.
- R8: In the N cycles that follow done, coef_valid is high and coef_idx steps through 0..N-1, with coef_data carrying that column's estimate as a signed value. After that the engine is idle again.
- R9: Each meas_we pulse while idle and without start writes meas_data to the next row. The k-th word after reset or after the last start goes to row k mod M. Writes while busy are ignored.
- R10: A dict_we pulse while idle and without start writes dict_data to row dict_row, column dict_col. Writes while busy are ignored.
- R11: No coefficient is presented before all iterations have finished. coef_valid is low outside the streaming window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the loaded block |
| meas_we | input | 1 | Measurement word write strobe |
| meas_data | input | 8 | Measurement word, signed |
| dict_we | input | 1 | Dictionary entry write strobe |
| dict_row | input | clog2(M) | Dictionary row of the write |
| dict_col | input | clog2(N) | Dictionary column of the write |
| dict_data | input | 8 | Dictionary entry, signed Q1.7 |
| busy | output | 1 | Block in progress, including output streaming |
| done | output | 1 | One-cycle pulse when the estimate is ready |
| coef_valid | output | 1 | Streamed coefficient is valid |
| coef_idx | output | clog2(N) | Column index of the streamed coefficient |
| coef_data | output | 16+clog2(M) | Streamed coefficient, signed |

## Verification
The engine is run with a measurement that tracks one dictionary column, which shows whether the selection locks onto that column across iterations. It is also run with a mix of two columns, which makes the residual update and the later selections depend on each other. All-minus-128 inputs separate an exact wide accumulator and a saturating residual from truncating ones. A dictionary with two identical columns separates lowest-index tie-breaking from any other order. Further runs cover a zero vector, overfilled measurement writes that wrap the write position, and start pulses and writes injected mid-run, which show that a busy engine ignores its load and start inputs.

// File: rtl/mp_pkg.sv
package mp_pkg;

    localparam int DW   = 8;
    localparam int FRAC = 7;
    localparam int PW   = 2 * DW;
    localparam int SMAX = (2 ** (DW - 1)) - 1;
    localparam int SMIN = -(2 ** (DW - 1));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CORR,
        ST_CMP,
        ST_UPD,
        ST_DONE,
        ST_STREAM
    } mp_state_e;

    function automatic logic signed [DW-1:0] sat_dw(input logic signed [31:0] v);
        if (v > SMAX) return DW'(SMAX);
        if (v < SMIN) return DW'(SMIN);
        return v[DW-1:0];
    endfunction

endpackage

// File: rtl/mp_mac_lane.sv
module mp_mac_lane
    import mp_pkg::*;
#(
    parameter int ACCW = 19
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   en,
    input  logic signed [DW-1:0]   coef_i,
    input  logic signed [DW-1:0]   samp_i,
    output logic signed [ACCW-1:0] acc_o
);

    logic signed [PW-1:0] prod;

    assign prod = coef_i * samp_i;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_o <= '0;
        end else if (en) begin
            acc_o <= acc_o + ACCW'(prod);
        end
    end

endmodule

// File: rtl/mp_maxsel.sv
module mp_maxsel
    import mp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ACCW  = 19,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic signed [ACCW-1:0] vals_i [LANES],
    output logic signed [ACCW-1:0] sel_val_o,
    output logic [LW-1:0]          sel_lane_o
);

    function automatic logic [ACCW-1:0] mag(input logic signed [ACCW-1:0] v);
        return v[ACCW-1] ? $unsigned(-v) : $unsigned(v);
    endfunction

    int best;

    // linear scan, strict compare keeps the lowest lane on equal magnitude
    always_comb begin
        best = 0;
        for (int l = 1; l < LANES; l++) begin
            if (mag(vals_i[l]) > mag(vals_i[best])) best = l;
        end
        sel_lane_o = LW'(best);
        sel_val_o  = vals_i[best];
    end

    // R4: no lane beats the pick; lanes below the pick are strictly smaller
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            p_lane_max_r4: assert (mag(vals_i[l]) <= mag(sel_val_o));
            if (l < int'(sel_lane_o)) begin
                p_lane_tie_r4: assert (mag(vals_i[l]) < mag(sel_val_o));
            end
        end
    end

endmodule

// File: rtl/mp_engine.sv
module mp_engine
    import mp_pkg::*;
#(
    parameter int M      = 8,
    parameter int N      = 16,
    parameter int LANES  = 4,
    parameter int ITERS  = 10,
    localparam int RW    = (M > 1) ? $clog2(M) : 1,
    localparam int CW    = (N > 1) ? $clog2(N) : 1,
    localparam int ACCW  = PW + $clog2(M)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   meas_we,
    input  logic [DW-1:0]          meas_data,
    input  logic                   dict_we,
    input  logic [RW-1:0]          dict_row,
    input  logic [CW-1:0]          dict_col,
    input  logic [DW-1:0]          dict_data,
    output logic                   busy,
    output logic                   done,
    output logic                   coef_valid,
    output logic [CW-1:0]          coef_idx,
    output logic signed [ACCW-1:0] coef_data
);

    localparam int G  = N / LANES;
    localparam int GW = (G > 1) ? $clog2(G) : 1;
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;

    typedef struct packed {
        logic [CW-1:0]          idx;
        logic signed [ACCW-1:0] val;
    } cand_t;

    function automatic logic [ACCW-1:0] mag(input logic signed [ACCW-1:0] v);
        return v[ACCW-1] ? $unsigned(-v) : $unsigned(v);
    endfunction

    mp_state_e             st_q;
    logic signed [DW-1:0]  meas_q [M];
    logic signed [DW-1:0]  res_q  [M];
    logic signed [DW-1:0]  res_nx [M];
    logic signed [DW-1:0]  dict_q [M][N];
    logic signed [ACCW-1:0] est_q [N];
    logic [RW-1:0]         wptr_q;
    logic [RW-1:0]         row_q;
    logic [GW-1:0]         grp_q;
    logic [IW-1:0]         iter_q;
    logic [CW-1:0]         oidx_q;
    cand_t                 best_q;
    cand_t                 cand;

    logic                   lane_en;
    logic                   lane_clr;
    logic signed [ACCW-1:0] lane_acc [LANES];
    logic signed [ACCW-1:0] sel_val;
    logic [LW-1:0]          sel_lane;
    logic signed [ACCW-1:0] alpha;

    assign lane_en  = (st_q == ST_CORR);
    assign lane_clr = (st_q != ST_CORR);

    // one lane per column of the current group, rows stepped in time
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CW-1:0] col;
        assign col = CW'(int'(grp_q) * LANES + l);
        mp_mac_lane #(.ACCW(ACCW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .clr    (lane_clr),
            .en     (lane_en),
            .coef_i (dict_q[row_q][col]),
            .samp_i (res_q[row_q]),
            .acc_o  (lane_acc[l])
        );
    end

    mp_maxsel #(.LANES(LANES), .ACCW(ACCW)) u_maxsel (
        .vals_i     (lane_acc),
        .sel_val_o  (sel_val),
        .sel_lane_o (sel_lane)
    );

    always_comb begin
        cand.idx = CW'(int'(grp_q) * LANES) + CW'(sel_lane);
        cand.val = sel_val;
    end

    assign alpha = best_q.val >>> FRAC;

    // residual step for the chosen column, all rows in parallel
    always_comb begin
        for (int i = 0; i < M; i++) begin
            logic signed [ACCW+DW-1:0] prod;
            logic signed [ACCW+DW-1:0] delta;
            logic signed [31:0]        diff;
            prod      = alpha * dict_q[i][best_q.idx];
            delta     = prod >>> FRAC;
            diff      = 32'(res_q[i]) - 32'(delta);
            res_nx[i] = sat_dw(diff);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            wptr_q <= '0;
            row_q  <= '0;
            grp_q  <= '0;
            iter_q <= '0;
            oidx_q <= '0;
            best_q <= '0;
            for (int i = 0; i < M; i++) begin
                meas_q[i] <= '0;
                res_q[i]  <= '0;
                for (int j = 0; j < N; j++) dict_q[i][j] <= '0;
            end
            for (int j = 0; j < N; j++) est_q[j] <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        for (int i = 0; i < M; i++) res_q[i] <= meas_q[i];
                        for (int j = 0; j < N; j++) est_q[j] <= '0;
                        wptr_q <= '0;
                        row_q  <= '0;
                        grp_q  <= '0;
                        iter_q <= '0;
                        st_q   <= ST_CORR;
                    end else begin
                        if (meas_we) begin
                            meas_q[wptr_q] <= meas_data;
                            wptr_q <= (wptr_q == RW'(M - 1)) ? '0 : wptr_q + 1'b1;
                        end
                        if (dict_we) dict_q[dict_row][dict_col] <= dict_data;
                    end
                end
                ST_CORR: begin
                    if (row_q == RW'(M - 1)) begin
                        row_q <= '0;
                        st_q  <= ST_CMP;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
                ST_CMP: begin
                    if (grp_q == '0 || mag(cand.val) > mag(best_q.val)) best_q <= cand;
                    if (grp_q == GW'(G - 1)) begin
                        grp_q <= '0;
                        st_q  <= ST_UPD;
                    end else begin
                        grp_q <= grp_q + 1'b1;
                        st_q  <= ST_CORR;
                    end
                end
                ST_UPD: begin
                    est_q[best_q.idx] <= est_q[best_q.idx] + alpha;
                    for (int i = 0; i < M; i++) res_q[i] <= res_nx[i];
                    if (iter_q == IW'(ITERS - 1)) begin
                        iter_q <= '0;
                        st_q   <= ST_DONE;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                        st_q   <= ST_CORR;
                    end
                end
                ST_DONE: begin
                    oidx_q <= '0;
                    st_q   <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (oidx_q == CW'(N - 1)) st_q <= ST_IDLE;
                    else oidx_q <= oidx_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign done       = (st_q == ST_DONE);
    assign coef_valid = (st_q == ST_STREAM);
    assign coef_idx   = oidx_q;
    assign coef_data  = est_q[oidx_q];

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !coef_valid) |=> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && coef_valid && coef_idx == '0));

    p_iter_bound_r7: assert property (@(posedge clk) disable iff (rst)
        iter_q <= IW'(ITERS - 1));

    p_stream_seq_r8: assert property (@(posedge clk) disable iff (rst)
        (coef_valid && coef_idx != CW'(N - 1)) |=>
            (coef_valid && coef_idx == $past(coef_idx) + CW'(1)));

    p_no_early_out_r11: assert property (@(posedge clk) disable iff (rst)
        coef_valid |-> $past(busy));

endmodule

// File: tb/test_mp_engine.sv
`timescale 1ns/1ps
module test_mp_engine;

    localparam int M     = 8;
    localparam int N     = 16;
    localparam int LANES = 4;
    localparam int ITERS = 10;
    localparam int RW    = 3;
    localparam int CW    = 4;
    localparam int AW    = 19;
    localparam int P     = ITERS * ((N / LANES) * (M + 1) + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          meas_we = 1'b0;
    logic [7:0]    meas_data = '0;
    logic          dict_we = 1'b0;
    logic [RW-1:0] dict_row = '0;
    logic [CW-1:0] dict_col = '0;
    logic [7:0]    dict_data = '0;
    logic          busy, done, coef_valid;
    logic [CW-1:0] coef_idx;
    logic signed [AW-1:0] coef_data;

    always #2.5 clk = ~clk;

    mp_engine #(.M(M), .N(N), .LANES(LANES), .ITERS(ITERS)) i_mp_engine (
        .clk(clk), .rst(rst), .start(start),
        .meas_we(meas_we), .meas_data(meas_data),
        .dict_we(dict_we), .dict_row(dict_row), .dict_col(dict_col), .dict_data(dict_data),
        .busy(busy), .done(done), .coef_valid(coef_valid),
        .coef_idx(coef_idx), .coef_data(coef_data)
    );

    int nchk = 0;
    int nerr = 0;
    int sm [M];
    int sd [M][N];
    int ex [N];
    int got [N];
    int wp = 0;
    int k = -1;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int sat8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    // behavioural matching pursuit on the bench's own copies of the inputs
    function automatic void model();
        int r [M];
        int c, bc, bj, a;
        for (int j = 0; j < N; j++) ex[j] = 0;
        for (int i = 0; i < M; i++) r[i] = sm[i];
        for (int it = 0; it < ITERS; it++) begin
            bj = -1; bc = 0;
            for (int j = 0; j < N; j++) begin
                c = 0;
                for (int i = 0; i < M; i++) c += sd[i][j] * r[i];
                if (bj < 0 || iabs(c) > iabs(bc)) begin bc = c; bj = j; end
            end
            a = bc >>> 7;
            ex[bj] += a;
            for (int i = 0; i < M; i++) r[i] = sat8(r[i] - ((a * sd[i][bj]) >>> 7));
        end
    endfunction

    // shadow of the load interface and the phase counter k (edges since start)
    always @(posedge clk) begin
        if (rst) begin
            k = -1; wp = 0;
            for (int i = 0; i < M; i++) begin
                sm[i] = 0;
                for (int j = 0; j < N; j++) sd[i][j] = 0;
            end
        end else if (k < 0) begin
            if (start) begin
                model(); k = 0; wp = 0;
            end else begin
                if (meas_we) begin sm[wp] = $signed(meas_data); wp = (wp + 1) % M; end
                if (dict_we) sd[dict_row][dict_col] = $signed(dict_data);
            end
        end else if (k == P + N) begin
            k = -1;
        end else begin
            k = k + 1;
        end
    end

    // cycle-by-cycle comparison against the expected phase
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 busy", int'(busy), int'(k >= 0));
            chk("R7 done", int'(done), int'(k == P));
            chk("R11 coef_valid", int'(coef_valid), int'(k >= P + 1 && k <= P + N));
            if (k >= P + 1 && k <= P + N) begin
                chk("R8 coef_idx", int'(coef_idx), k - P - 1);
                chk("R5 coef_data", int'(coef_data), ex[k - P - 1]);
                got[k - P - 1] = int'(coef_data);
            end
        end
    end

    function automatic int dval(input int seed, input int i, input int j);
        return ((i * 37 + j * 53 + seed * 17) % 251) - 125;
    endfunction

    task automatic wr_dict(input int i, input int j, input int v);
        @(negedge clk);
        dict_we = 1'b1; dict_row = RW'(i); dict_col = CW'(j); dict_data = 8'(v);
        @(negedge clk);
        dict_we = 1'b0;
    endtask

    task automatic load_dict(input int seed, input int fixed, input bit use_fixed);
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < N; j++) begin
                @(negedge clk);
                dict_we = 1'b1; dict_row = RW'(i); dict_col = CW'(j);
                dict_data = use_fixed ? 8'(fixed) : 8'(dval(seed, i, j));
            end
        end
        @(negedge clk);
        dict_we = 1'b0;
    endtask

    task automatic wr_meas(input int v);
        @(negedge clk);
        meas_we = 1'b1; meas_data = 8'(v);
        @(negedge clk);
        meas_we = 1'b0;
    endtask

    task automatic run_block(input string tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do @(negedge clk); while (busy);
        for (int j = 0; j < N; j++) chk(tag, got[j], ex[j]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 coef_valid", int'(coef_valid), 0);

        // one column dominant (R4, R5, R6, R10)
        load_dict(1, 0, 1'b0);
        for (int i = 0; i < M; i++) wr_meas(dval(1, i, 5) / 2);
        run_block("R5 one-column block");

        // two-column mix (R5, R6)
        for (int i = 0; i < M; i++) wr_meas((dval(1, i, 2) + dval(1, i, 11)) / 3);
        run_block("R6 two-column block");

        // start and writes while busy are ignored (R2, R9, R10)
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wr_meas(99); wr_meas(-77);
        wr_dict(0, 0, 55);
        do @(negedge clk); while (busy);
        for (int j = 0; j < N; j++) chk("R2 busy-start ignored", got[j], ex[j]);
        run_block("R9 R10 busy writes ignored");

        // extremes: all -128 (R3, R6)
        load_dict(0, -128, 1'b1);
        for (int i = 0; i < M; i++) wr_meas(-128);
        run_block("R3 extreme block");
        chk("R3 column 0 estimate", got[0], ex[0]);

        // tie between identical columns 3 and 9 (R4)
        load_dict(2, 0, 1'b0);
        for (int i = 0; i < M; i++) wr_dict(i, 9, dval(2, i, 3));
        for (int i = 0; i < M; i++) wr_meas(dval(2, i, 3));
        run_block("R4 tie block");
        chk("R4 higher duplicate unused", got[9], 0);

        // write position wraps: rows 0 and 1 overwritten (R9)
        for (int i = 0; i < M; i++) wr_meas(10 * i - 40);
        wr_meas(120); wr_meas(-120);
        run_block("R9 wrap block");

        // zero vector (R5)
        for (int i = 0; i < M; i++) wr_meas(0);
        run_block("R5 zero block");
        for (int j = 0; j < N; j++) chk("R5 zero estimate", got[j], 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule